// File: doc/BRIEF.md
# Packet-Command PIO Read Controller

This block is the device side of a storage register interface that runs the packet command in programmed-I/O mode. The host loads a 16-bit byte-count limit into two byte-wide count registers and issues command 0xA0. The block then raises DRQ and takes a 12-byte command packet as six 16-bit writes to the data port. When the packet is a READ(10), the block streams the requested 2048-byte blocks out of the data port, one 16-bit word per host read.

Words come from a block source that the block addresses with a registered block address and a word offset. The source returns the word combinationally for the current address. The transfer is split into chunks that never exceed the even-rounded limit. Each chunk is announced by an interrupt, and the chunk's byte count appears in the count registers. One more interrupt marks the end of the data. Any packet opcode other than READ(10), and any command other than 0xA0, ends at once with an error and an abort indication.

Top module: `atapi_pio_ctrl`

## Requirements
- R1: After reset the status register (address 7) reads 0x40, the error register (address 1) reads 0x00, both count registers (addresses 4 and 5) read 0x00, and `irq` is low.
- R2: In idle, writes to address 4 set the low byte of the count register and writes to address 5 set its high byte. Command 0xA0 written to address 7 latches that value as the limit. From the next cycle the status reads 0x48 (DRQ bit 3 and DRDY bit 6 set, BSY bit 7 clear).
- R3: The packet is six writes to address 0, each word carrying the earlier packet byte in bits 7:0. Byte 0 is the opcode, and READ(10) is 0x28. Bytes 2 to 5 hold a big-endian block address and bytes 7 to 8 hold a big-endian block count. From the cycle after the sixth write the status reads 0xC0 (BSY and DRDY).
- R4: Each chunk is the smaller of the remaining bytes and the limit with bit 0 cleared. A limit below 2 counts as 0xFFFE. A block is 2048 bytes.
- R5: A chunk opens on the third clock edge after the sixth packet write, or on the second edge after the last word of the previous chunk. At that point `irq` rises, the status reads 0x48, and the count registers hold the chunk's byte count (low byte at address 4).
- R6: The n-th word of a transfer (n from 0) is read from the block source at block address start + n/1024 and word offset n mod 1024. Each data-port read during a chunk returns that word and moves to the next one.
- R7: Between two chunks the status reads 0xC0 for exactly one cycle, with `irq` low.
- R8: After the last word of the last chunk, `irq` is high and the status reads 0x40 from the next cycle.
- R9: A host read of the status register clears `irq`. If the block raises `irq` in the same cycle, `irq` stays high.
- R10: An unsupported packet opcode, or any idle command other than 0xA0, leaves the status at 0x41 (ERR bit 0) and the error register at 0x04 (abort bit 2), and raises `irq`. The next 0xA0 command clears both.
- R11: A READ(10) with a block count of zero ends without a data phase: `irq` is high and the status reads 0x40.
- R12: While not idle, writes to the count and command registers have no effect. Data-port reads outside a chunk return 0x0000 and leave the source address unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Host register write strobe |
| host_rd | input | 1 | Host register read strobe (status and data reads have side effects) |
| host_addr | input | 3 | Register address: 0 data, 1 error, 4 count low, 5 count high, 7 status/command |
| host_wdata | input | 16 | Write data (byte registers use bits 7:0) |
| host_rdata | output | 16 | Read data for the addressed register |
| irq | output | 1 | Interrupt request to the host |
| src_lba | output | 32 | Block address presented to the block source |
| src_word | output | 10 | Word offset within the block presented to the block source |
| src_data | input | 16 | Word returned by the block source for the current address |

## Verification
If the block lost track of the remaining byte or word counts, the host would see it at the next chunk boundary. The count registers would show a wrong size, `irq` would rise on the wrong cycle, or the end-of-data status would come early or late. The per-clock comparison of `irq` catches any of these on the edge where it happens. A wrong source pointer shows up on the very next data-port read as a word that does not match the block address and offset pattern. A corrupted packet decode shows up two edges after the sixth word, as a wrong error status or a wrong first chunk size.

// File: rtl/atapi_pio_pkg.sv
package atapi_pio_pkg;
   localparam int LBA_W = 32;
   localparam int BLK_W = 16;
   localparam int CNT_W = 16;

   localparam logic [2:0] A_DATA   = 3'd0;
   localparam logic [2:0] A_ERROR  = 3'd1;
   localparam logic [2:0] A_CNT_LO = 3'd4;
   localparam logic [2:0] A_CNT_HI = 3'd5;
   localparam logic [2:0] A_STAT   = 3'd7;

   localparam logic [7:0] CMD_PKT  = 8'hA0;
   localparam logic [7:0] OP_RD10  = 8'h28;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PKT,
      ST_DECODE,
      ST_LOAD,
      ST_XFER
   } st_e;
endpackage

// File: rtl/atapi_pkt_collect.sv
module atapi_pkt_collect #(
   parameter int PKT_WORDS = 6,
   localparam int IW = $clog2(PKT_WORDS)
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        clr,
   input  logic        wr,
   input  logic [15:0] wdata,
   output logic        last,
   output logic [7:0]  op,
   output logic [31:0] lba,
   output logic [15:0] blocks
);
   logic [IW-1:0] idx_q;

   generate
      if (PKT_WORDS < 5) begin : g_bad_len
         $error("packet must reach byte 8");
      end
   endgenerate

   assign last = wr && (idx_q == IW'(PKT_WORDS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q  <= '0;
         op     <= '0;
         lba    <= '0;
         blocks <= '0;
      end else if (clr) begin
         idx_q <= '0;
      end else if (wr) begin
         idx_q <= idx_q + IW'(1);
         case (idx_q)
            IW'(0): op           <= wdata[7:0];
            IW'(1): lba[31:16]   <= {wdata[7:0], wdata[15:8]};
            IW'(2): lba[15:0]    <= {wdata[7:0], wdata[15:8]};
            IW'(3): blocks[15:8] <= wdata[15:8];
            IW'(4): blocks[7:0]  <= wdata[7:0];
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/atapi_chunk_calc.sv
module atapi_chunk_calc #(
   parameter int REM_W = 27,
   parameter int CNT_W = 16,
   parameter bit ZERO_LIMIT_MAX = 1'b1
) (
   input  logic [REM_W-1:0] remaining,
   input  logic [CNT_W-1:0] limit,
   output logic [CNT_W-1:0] chunk
);
   logic [CNT_W-1:0] lim_even;
   logic [CNT_W-1:0] eff;

   assign lim_even = limit & ~CNT_W'(1);

   generate
      if (ZERO_LIMIT_MAX) begin : g_zero_max
         assign eff = (lim_even == '0) ? {{(CNT_W-1){1'b1}}, 1'b0} : lim_even;
      end else begin : g_zero_min
         assign eff = (lim_even == '0) ? CNT_W'(2) : lim_even;
      end

      if (REM_W > CNT_W) begin : g_wide_rem
         assign chunk = (remaining < REM_W'(eff)) ? remaining[CNT_W-1:0] : eff;
      end else begin : g_narrow_rem
         assign chunk = (CNT_W'(remaining) < eff) ? CNT_W'(remaining) : eff;
      end
   endgenerate
endmodule

// File: rtl/atapi_xfer_ptr.sv
module atapi_xfer_ptr #(
   parameter int LBA_W  = 32,
   parameter int WIDX_W = 10,
   localparam int POS_W = LBA_W + WIDX_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [LBA_W-1:0]  lba_in,
   input  logic              adv,
   output logic [LBA_W-1:0]  lba,
   output logic [WIDX_W-1:0] widx
);
   logic [POS_W-1:0] pos_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    pos_q <= '0;
      else if (load) pos_q <= {lba_in, WIDX_W'(0)};
      else if (adv)  pos_q <= pos_q + POS_W'(1);
   end

   assign lba  = pos_q[POS_W-1:WIDX_W];
   assign widx = pos_q[WIDX_W-1:0];
endmodule

// File: rtl/atapi_pio_ctrl.sv
module atapi_pio_ctrl
   import atapi_pio_pkg::*;
#(
   parameter int BLOCK_BYTES    = 2048,
   parameter int PKT_WORDS      = 6,
   parameter bit ZERO_LIMIT_MAX = 1'b1,
   localparam int BSH    = $clog2(BLOCK_BYTES),
   localparam int WIDX_W = BSH - 1,
   localparam int REM_W  = BLK_W + BSH
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_wr,
   input  logic              host_rd,
   input  logic [2:0]        host_addr,
   input  logic [15:0]       host_wdata,
   output logic [15:0]       host_rdata,
   output logic              irq,
   output logic [LBA_W-1:0]  src_lba,
   output logic [WIDX_W-1:0] src_word,
   input  logic [15:0]       src_data
);
   generate
      if ((BLOCK_BYTES & (BLOCK_BYTES - 1)) != 0 || BLOCK_BYTES < 4) begin : g_bad_blk
         $error("block size must be a power of two of at least 4");
      end
   endgenerate

   st_e              state_q;
   logic [CNT_W-1:0] cnt_q, lim_q;
   logic [REM_W-1:0] rem_q;
   logic [CNT_W-2:0] wleft_q;
   logic             err_q, abrt_q, irq_q;

   logic             wr_data, wr_lo, wr_hi, wr_cmd, rd_data, rd_stat;
   logic             bsy, drq;
   logic             pkt_last;
   logic [7:0]       pkt_op;
   logic [31:0]      pkt_lba;
   logic [15:0]      pkt_blocks;
   logic [CNT_W-1:0] chunk;

   assign wr_data = host_wr && host_addr == A_DATA;
   assign wr_lo   = host_wr && host_addr == A_CNT_LO;
   assign wr_hi   = host_wr && host_addr == A_CNT_HI;
   assign wr_cmd  = host_wr && host_addr == A_STAT;
   assign rd_data = host_rd && host_addr == A_DATA;
   assign rd_stat = host_rd && host_addr == A_STAT;

   atapi_pkt_collect #(.PKT_WORDS(PKT_WORDS)) u_pkt (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (state_q == ST_IDLE && wr_cmd),
      .wr     (state_q == ST_PKT && wr_data),
      .wdata  (host_wdata),
      .last   (pkt_last),
      .op     (pkt_op),
      .lba    (pkt_lba),
      .blocks (pkt_blocks)
   );

   atapi_chunk_calc #(
      .REM_W(REM_W), .CNT_W(CNT_W), .ZERO_LIMIT_MAX(ZERO_LIMIT_MAX)
   ) u_chunk (
      .remaining (rem_q),
      .limit     (lim_q),
      .chunk     (chunk)
   );

   atapi_xfer_ptr #(.LBA_W(LBA_W), .WIDX_W(WIDX_W)) u_ptr (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (state_q == ST_DECODE),
      .lba_in (pkt_lba),
      .adv    (state_q == ST_XFER && rd_data),
      .lba    (src_lba),
      .widx   (src_word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         lim_q   <= '0;
         rem_q   <= '0;
         wleft_q <= '0;
         err_q   <= 1'b0;
         abrt_q  <= 1'b0;
         irq_q   <= 1'b0;
      end else begin
         if (rd_stat) irq_q <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (wr_lo) cnt_q[7:0]  <= host_wdata[7:0];
               if (wr_hi) cnt_q[15:8] <= host_wdata[7:0];
               if (wr_cmd) begin
                  if (host_wdata[7:0] == CMD_PKT) begin
                     err_q   <= 1'b0;
                     abrt_q  <= 1'b0;
                     lim_q   <= cnt_q;
                     state_q <= ST_PKT;
                  end else begin
                     err_q  <= 1'b1;
                     abrt_q <= 1'b1;
                     irq_q  <= 1'b1;
                  end
               end
            end
            ST_PKT: begin
               if (pkt_last) state_q <= ST_DECODE;
            end
            ST_DECODE: begin
               if (pkt_op == OP_RD10) begin
                  if (pkt_blocks == '0) begin
                     irq_q   <= 1'b1;
                     state_q <= ST_IDLE;
                  end else begin
                     rem_q   <= {pkt_blocks, BSH'(0)};
                     state_q <= ST_LOAD;
                  end
               end else begin
                  err_q   <= 1'b1;
                  abrt_q  <= 1'b1;
                  irq_q   <= 1'b1;
                  state_q <= ST_IDLE;
               end
            end
            ST_LOAD: begin
               cnt_q   <= chunk;
               wleft_q <= chunk[CNT_W-1:1];
               irq_q   <= 1'b1;
               state_q <= ST_XFER;
            end
            ST_XFER: begin
               if (rd_data) begin
                  rem_q   <= rem_q - REM_W'(2);
                  wleft_q <= wleft_q - (CNT_W-1)'(1);
                  if (wleft_q == (CNT_W-1)'(1)) begin
                     if (rem_q == REM_W'(2)) begin
                        irq_q   <= 1'b1;
                        state_q <= ST_IDLE;
                     end else begin
                        state_q <= ST_LOAD;
                     end
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign bsy = (state_q == ST_DECODE) || (state_q == ST_LOAD);
   assign drq = (state_q == ST_PKT) || (state_q == ST_XFER);
   assign irq = irq_q;

   always_comb begin
      host_rdata = 16'h0000;
      case (host_addr)
         A_DATA:   host_rdata = (state_q == ST_XFER) ? src_data : 16'h0000;
         A_ERROR:  host_rdata = {13'd0, abrt_q, 2'b00};
         A_CNT_LO: host_rdata = {8'h00, cnt_q[7:0]};
         A_CNT_HI: host_rdata = {8'h00, cnt_q[15:8]};
         A_STAT:   host_rdata = {8'h00, bsy, 1'b1, 2'b00, drq, 2'b00, err_q};
         default:  host_rdata = 16'h0000;
      endcase
   end
endmodule

// File: rtl/atapi_pio_ctrl_chk.sv
module atapi_pio_ctrl_chk
   import atapi_pio_pkg::*;
#(
   parameter int WIDX_W = 10
) (
   input logic              clk,
   input logic              rst_n,
   input logic              host_wr,
   input logic              host_rd,
   input logic [2:0]        host_addr,
   input logic [15:0]       host_wdata,
   input logic              irq,
   input logic [WIDX_W-1:0] src_word,
   input st_e               state,
   input logic              bsy,
   input logic              drq,
   input logic [15:0]       cnt,
   input logic [15:0]       lim,
   input logic              err,
   input logic              abrt
);
   p_pkt_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && host_addr == A_STAT && host_wdata[7:0] == CMD_PKT && state == ST_IDLE)
      |=> (drq && !bsy));

   p_chunk_even_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_XFER) |-> (cnt[0] == 1'b0 && cnt != 16'd0 && (lim < 16'd2 || cnt <= lim)));

   p_word_advance_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_XFER && host_rd && host_addr == A_DATA)
      |=> (src_word == $past(src_word) + WIDX_W'(1)));

   p_word_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (state != ST_DECODE && !(host_rd && host_addr == A_DATA)) |=> $stable(src_word));

   p_irq_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> (state == ST_XFER || state == ST_IDLE));

   p_abort_pair_r10: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> abrt);

   p_bsy_drq_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(bsy && drq));
endmodule

bind atapi_pio_ctrl atapi_pio_ctrl_chk #(.WIDX_W(WIDX_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .host_wr    (host_wr),
   .host_rd    (host_rd),
   .host_addr  (host_addr),
   .host_wdata (host_wdata),
   .irq        (irq),
   .src_word   (src_word),
   .state      (state_q),
   .bsy        (bsy),
   .drq        (drq),
   .cnt        (cnt_q),
   .lim        (lim_q),
   .err        (err_q),
   .abrt       (abrt_q)
);

// File: tb/tb_atapi_pio_ctrl.sv
module tb_atapi_pio_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_wr = 1'b0;
   logic        host_rd = 1'b0;
   logic [2:0]  host_addr = 3'd0;
   logic [15:0] host_wdata = 16'h0000;
   logic [15:0] host_rdata;
   logic        irq;
   logic [31:0] src_lba;
   logic [9:0]  src_word;
   logic [15:0] src_data;

   int   checks = 0;
   int   fails = 0;
   logic exp_irq = 1'b0;
   bit   mon_en = 1'b0;
   bit   done = 1'b0;

   always #5 clk = ~clk;

   function automatic logic [15:0] pat(input logic [31:0] l, input logic [9:0] w);
      return {l[5:0], w} ^ 16'h5AA5;
   endfunction

   assign src_data = pat(src_lba, src_word);

   atapi_pio_ctrl dut (
      .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
      .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .irq(irq), .src_lba(src_lba), .src_word(src_word), .src_data(src_data)
   );

   // reference irq compared on every clock (R5, R8, R9)
   always @(posedge clk) begin
      #2;
      if (mon_en && !done) begin
         checks++;
         if (irq !== exp_irq) begin
            fails++;
            $display("FAIL R9 irq at %0t: got %0b expected %0b", $time, irq, exp_irq);
         end
      end
   end

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic hw(input logic [2:0] a, input logic [15:0] d, input int irqa);
      @(negedge clk);
      host_wr = 1'b1; host_addr = a; host_wdata = d;
      #1;
      if (irqa >= 0) exp_irq = irqa[0];
      @(posedge clk);
      #1 host_wr = 1'b0;
   endtask

   task automatic hr(input logic [2:0] a, input logic [15:0] exp, input string req, input int irqa);
      @(negedge clk);
      host_rd = 1'b1; host_addr = a;
      #1;
      chk(req, host_rdata, exp);
      if (irqa >= 0) exp_irq = irqa[0];
      @(posedge clk);
      #1 host_rd = 1'b0;
   endtask

   task automatic run_pkt(input logic [15:0] limit, input logic [7:0] op,
                          input logic [31:0] lba, input logic [15:0] nblk, input bit poke);
      logic [7:0] b [12];
      bit valid;
      int rem, k, lim_e, chunk;
      bit first;
      hw(3'd4, {8'h00, limit[7:0]}, -1);
      hw(3'd5, {8'h00, limit[15:8]}, -1);
      hw(3'd7, 16'h00A0, -1);
      hr(3'd7, 16'h0048, "R2", 0);
      foreach (b[i]) b[i] = 8'h00;
      b[0] = op; b[1] = 8'h11;
      b[2] = lba[31:24]; b[3] = lba[23:16]; b[4] = lba[15:8]; b[5] = lba[7:0];
      b[7] = nblk[15:8]; b[8] = nblk[7:0];
      for (int i = 0; i < 6; i++) hw(3'd0, {b[2*i+1], b[2*i]}, -1);
      valid = (op == 8'h28) && (nblk != 16'd0);
      hr(3'd7, 16'h00C0, "R3", valid ? 0 : 1);
      if (!valid) begin
         if (op == 8'h28) hr(3'd7, 16'h0040, "R11", 0);
         else begin
            hr(3'd7, 16'h0041, "R10", 0);
            hr(3'd1, 16'h0004, "R10", -1);
         end
         return;
      end
      hr(3'd7, 16'h00C0, "R3", 1);
      rem = int'(nblk) * 2048;
      k = 0;
      first = 1'b1;
      lim_e = int'(limit) & 32'hFFFE;
      if (lim_e == 0) lim_e = 65534;
      while (rem > 0) begin
         chunk = (rem < lim_e) ? rem : lim_e;
         hr(3'd7, 16'h0048, "R5", 0);
         hr(3'd4, 16'(chunk & 255), "R4", -1);
         hr(3'd5, 16'((chunk >> 8) & 255), "R4", -1);
         if (poke && first) begin
            hw(3'd4, 16'h0055, -1);
            hw(3'd7, 16'h00A0, -1);
            hr(3'd4, 16'(chunk & 255), "R12", -1);
            hr(3'd7, 16'h0048, "R12", -1);
         end
         first = 1'b0;
         for (int j = 0; j < chunk / 2; j++) begin
            logic [31:0] el;
            el = lba + 32'(k / 1024);
            hr(3'd0, pat(el, 10'(k % 1024)), "R6",
               ((j == chunk / 2 - 1) && (rem == chunk)) ? 1 : -1);
            k++;
         end
         rem -= chunk;
         if (rem > 0) hr(3'd7, 16'h00C0, "R7", 1);
      end
      hr(3'd7, 16'h0040, "R8", 0);
   endtask

   initial begin
      logic [9:0] w0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      mon_en = 1'b1;
      // R1 reset state
      hr(3'd7, 16'h0040, "R1", -1);
      hr(3'd1, 16'h0000, "R1", -1);
      hr(3'd4, 16'h0000, "R1", -1);
      hr(3'd5, 16'h0000, "R1", -1);
      // single block, chunk equals the whole block
      run_pkt(16'd5120, 8'h28, 32'd0, 16'd1, 1'b0);
      // odd limit rounded down, crossing a block boundary, writes ignored mid-transfer (R12)
      run_pkt(16'd5121, 8'h28, 32'd7, 16'd3, 1'b1);
      // uneven split with short last chunk
      run_pkt(16'd3000, 8'h28, 32'h12345678, 16'd2, 1'b0);
      // limit below 2 treated as maximum (R4)
      run_pkt(16'd1, 8'h28, 32'd40, 16'd33, 1'b0);
      // zero block count (R11)
      run_pkt(16'd512, 8'h28, 32'd3, 16'd0, 1'b0);
      // unsupported opcode (R10)
      run_pkt(16'd512, 8'h12, 32'd3, 16'd1, 1'b0);
      // non-packet command in idle (R10)
      hw(3'd7, 16'h00EC, 1);
      hr(3'd7, 16'h0041, "R10", 0);
      hr(3'd1, 16'h0004, "R10", -1);
      // next packet command clears the error (R10)
      run_pkt(16'd2048, 8'h28, 32'd1, 16'd1, 1'b0);
      hr(3'd1, 16'h0000, "R10", -1);
      // data read while idle (R12)
      w0 = src_word;
      hr(3'd0, 16'h0000, "R12", -1);
      chk("R12", {6'd0, src_word}, {6'd0, w0});
      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule